// File: doc/BRIEF.md
# Four-lane single-precision to E5M2 narrowing converter

The block narrows four floating-point values per beat into the 8-bit E5M2 format (one sign bit, a 5-bit exponent with bias 15, and a 2-bit mantissa). Each 32-bit lane either carries a full single-precision value or, when the mode input is high, a bfloat16 value in its upper half. The exponent is rebiased from 8 bits to 5. The low end of the E5M2 range is not produced by a shifter. Instead, the source mantissa is snapped to one of a few quarter-step values, chosen from the source exponent. One biased add then rounds every value to nearest, with ties to even. Any value too large for E5M2, infinity included, clamps to the largest finite magnitude. A NaN comes out as the canonical quiet NaN.

Data enters and leaves through valid/ready streams, and each side has one 128-bit or 32-bit word per beat. An input word is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. The converted word is presented on the next cycle and stays on the output until the downstream side takes it with `out_ready`. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. An upstream source may therefore hold `in_valid` high with stable data for as long as it needs to. The downstream side may stall by holding `out_ready` low for any number of cycles, and no beat is lost or duplicated.

Top module: `e5m2_pack_cvt`

## Requirements
- R1: For a single-precision lane (`in_mode`=0), the sign is bit 31, the exponent is bits 30:23 and the mantissa is bits 22:0. A source exponent e of 0x71 or more gives an output exponent of e-0x70 in output bits 6:2, so 1.0 (0x3F800000) converts to 0x3C.
- R2: A source exponent below 0x6E gives an output magnitude of 0, whatever the mantissa.
- R3: For source exponents 0x6E to 0x70 the mantissa is first replaced by a fixed value, and the output exponent is 0 before rounding:
  - At 0x6E the mantissa becomes 0x200000 if it is nonzero, and 0 otherwise.
  - At 0x6F it becomes 0x400000 if it is 0x400000 or more, and 0x200000 otherwise.
  - At 0x70 it becomes 0x400000 if it is 0x200000 or less, 0x600000 if it is below 0x600000, and 0x800000 otherwise.
- R4: Rounding adds 0xFFFFF plus bit 21 of s = (exp5<<23)|mantissa. The output magnitude is bits 27:21 of the sum. This rounds to nearest with ties to even, so 0x3F900000 gives 0x3C and 0x3FB00000 gives 0x3E.
- R5: A source exponent above 0x8E, or s of 0x0F700000 or more, gives magnitude 0x7B. This includes infinity (exponent 0xFF with a zero mantissa).
- R6: Exponent 0xFF with a nonzero mantissa gives magnitude 0x7E.
- R7: Output bit 7 equals the source sign bit in every case, including zero, saturation and NaN.
- R8: With `in_mode`=1 the lane value is the bfloat16 held in bits 31:16, with the exponent at bits 30:23 and a 7-bit mantissa at bits 22:16. Bits 15:0 have no effect. For example, 0x3F900001 gives 0x3C, and 0x7F800001 gives 0x7B because it is infinity.
- R9: Lane i is taken from `in_data[32i+31:32i]` and delivered on `out_data[8i+7:8i]`. The lanes are independent of each other, and all four share the mode sampled with the beat.
- R10: After reset `out_valid` is 0 and `in_ready` is 1. An accepted beat sets `out_valid` on the next rising edge.
- R11: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Converter can take a beat |
| in_mode | input | 1 | 0: lanes are single precision, 1: lanes are bfloat16 in bits 31:16 |
| in_data | input | 128 | Four 32-bit source lanes |
| out_valid | output | 1 | Converted beat present |
| out_ready | input | 1 | Downstream takes the beat |
| out_data | output | 32 | Four E5M2 bytes |

## Verification
The block has two behaviours that can land in the same cycle: back-pressure hold and fresh conversion. A stalled output must keep its word while a new beat waits at the input. The bench provokes this by toggling `out_ready` at random while the driver keeps offering beats. It judges the result in two ways. The held word must not change from one cycle to the next. The scoreboard must then receive every beat exactly once and in order, once `out_ready` returns. A single beat also mixes saturation, NaN, snapped subnormals and ties across its lanes, so that each lane's classification is shown to be independent of its neighbours.

// File: rtl/e5m2_pkg.sv
`timescale 1ns/1ps
package e5m2_pkg;
  localparam int SRC_W   = 32;
  localparam int DST_W   = 8;
  localparam int EXP_W   = 8;
  localparam int MAN_W   = 23;
  localparam int E5_W    = 5;

  localparam logic [EXP_W-1:0] REBIAS     = 8'h70;
  localparam logic [EXP_W-1:0] SNAP_LO    = 8'h6E;
  localparam logic [EXP_W-1:0] SNAP_MID   = 8'h6F;
  localparam logic [EXP_W-1:0] SNAP_HI    = 8'h70;
  localparam logic [EXP_W-1:0] EXP_LIMIT  = 8'h8E;
  localparam logic [EXP_W-1:0] EXP_SPEC   = 8'hFF;

  localparam logic [MAN_W:0] QUARTER = 24'h200000;
  localparam logic [MAN_W:0] HALF    = 24'h400000;
  localparam logic [MAN_W:0] THREEQ  = 24'h600000;
  localparam logic [MAN_W:0] ONE     = 24'h800000;

  localparam logic [31:0] RND_BASE  = 32'h000FFFFF;
  localparam logic [31:0] OVF_EDGE  = 32'h0F700000;
  localparam logic [31:0] SAT_WORD  = 32'h0F7FFFFF;
  localparam logic [31:0] QNAN_WORD = 32'h0FC00000;

  typedef enum logic { SRC_FP32 = 1'b0, SRC_BF16 = 1'b1 } src_fmt_e;
endpackage

// File: rtl/e5m2_lane.sv
`timescale 1ns/1ps
module e5m2_lane
  import e5m2_pkg::*;
(
  input  logic [SRC_W-1:0] src,
  input  logic             fmt,
  output logic [DST_W-1:0] dst
);
  logic [SRC_W-1:0] wide;
  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] mn;
  logic [EXP_W-1:0] ex_diff;
  logic [E5_W-1:0]  e5;
  logic [MAN_W:0]   mn_snap;
  logic [31:0]      sig;
  logic [31:0]      rnd;
  logic [31:0]      mag;
  logic             is_nan, is_sat;
  logic             unused_low;

  // bfloat16 is single precision with the low half cleared; the rounding
  // constant's low 16 ones never carry, so one datapath serves both formats
  assign wide = (src_fmt_e'(fmt) == SRC_BF16) ? {src[31:16], 16'h0000} : src;
  assign sgn  = wide[31];
  assign ex   = wide[30:23];
  assign mn   = wide[22:0];

  assign ex_diff = ex - REBIAS;
  assign e5      = (ex < SNAP_HI + 8'd1) ? '0 : ex_diff[E5_W-1:0];

  always_comb begin
    if (ex < SNAP_LO)
      mn_snap = '0;
    else if (ex == SNAP_LO)
      mn_snap = (mn != '0) ? QUARTER : '0;
    else if (ex == SNAP_MID)
      mn_snap = ({1'b0, mn} >= HALF) ? HALF : QUARTER;
    else if (ex == SNAP_HI) begin
      if ({1'b0, mn} <= QUARTER)      mn_snap = HALF;
      else if ({1'b0, mn} < THREEQ)   mn_snap = THREEQ;
      else                            mn_snap = ONE;
    end else
      mn_snap = {1'b0, mn};
  end

  assign sig    = ({27'b0, e5} << MAN_W) | {8'b0, mn_snap};
  assign rnd    = sig + RND_BASE + {31'b0, sig[21]};
  assign is_nan = (ex == EXP_SPEC) && (mn != '0);
  assign is_sat = (ex > EXP_LIMIT) || (sig >= OVF_EDGE);

  always_comb begin
    if (is_nan)      mag = QNAN_WORD;
    else if (is_sat) mag = SAT_WORD;
    else             mag = rnd;
  end

  assign dst        = {sgn, mag[27:21]};
  assign unused_low = ^{mag[31:28], mag[20:0]};
endmodule

// File: rtl/e5m2_stage.sv
`timescale 1ns/1ps
module e5m2_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign up_ready = !full_q || dn_ready;
  assign dn_valid = full_q;
  assign dn_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (up_valid && up_ready) begin
      full_q <= 1'b1;
      data_q <= up_data;
    end else if (dn_ready) begin
      full_q <= 1'b0;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_data)) else $error("hold"); // R11
  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_ready |=> dn_valid) else $error("latency"); // R10
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_ready && !up_valid |=> !dn_valid) else $error("drain"); // R10
endmodule

// File: rtl/e5m2_pack_cvt.sv
`timescale 1ns/1ps
module e5m2_pack_cvt
  import e5m2_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   in_mode,
  input  logic [LANES*SRC_W-1:0] in_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LANES*DST_W-1:0] out_data
);
  localparam int OUT_W = LANES * DST_W;

  logic [OUT_W-1:0] conv;
  logic             accept;

  assign accept = in_valid && in_ready;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    e5m2_lane u_lane (
      .src (in_data[l*SRC_W +: SRC_W]),
      .fmt (in_mode),
      .dst (conv[l*DST_W +: DST_W])
    );

    AST_SIGN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> out_data[l*DST_W+7] == $past(in_data[l*SRC_W+31])) else $error("sign"); // R7
    AST_INF_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      accept && in_data[l*SRC_W+23 +: 8] == 8'hFF && in_data[l*SRC_W+16 +: 7] == 7'h0
      && (in_mode || in_data[l*SRC_W +: 16] == 16'h0)
      |=> out_data[l*DST_W +: 7] == 7'h7B) else $error("sat"); // R5
    AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !in_mode && in_data[l*SRC_W+23 +: 8] == 8'hFF && in_data[l*SRC_W +: 23] != 23'h0
      |=> out_data[l*DST_W +: 7] == 7'h7E) else $error("nan"); // R6
    AST_TINY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      accept && in_data[l*SRC_W+23 +: 8] < 8'h6E
      |=> out_data[l*DST_W +: 7] == 7'h00) else $error("tiny"); // R2
  end

  e5m2_stage #(.W(OUT_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (conv),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_data)
  );
endmodule

// File: tb/sim_e5m2_pack_cvt.sv
`timescale 1ns/1ps
module sim_e5m2_pack_cvt;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         in_mode = 1'b0;
  logic [127:0] in_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [31:0]  out_data;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb[$];

  int  checks = 0;
  int  fails = 0;
  bit  run_done = 0;
  bit  rnd_ready = 0;

  always #2.5 clk = ~clk;

  e5m2_pack_cvt u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [7:0] ref_f32(input logic [31:0] x);
    logic [7:0] e; logic [31:0] m, e5, s, r;
    e = x[30:23]; m = {9'b0, x[22:0]};
    e5 = (e < 8'h71) ? 0 : {24'b0, e} - 32'h70;
    if (e < 8'h6E) m = 0;
    else if (e == 8'h6E) m = (m != 0) ? 32'h200000 : 0;
    else if (e == 8'h6F) m = (m >= 32'h400000) ? 32'h400000 : 32'h200000;
    else if (e == 8'h70) m = (m > 32'h200000) ? ((m >= 32'h600000) ? 32'h800000 : 32'h600000) : 32'h400000;
    s = (e5 << 23) | m;
    r = s + 32'hFFFFF + ((s >> 21) & 1);
    if (e > 8'h8E || s >= 32'h0F700000) r = 32'h0F7FFFFF;
    if (e == 8'hFF && x[22:0] != 0) r = 32'h0FC00000;
    r = r | ({31'b0, x[31]} << 28);
    return r[28:21];
  endfunction

  function automatic logic [7:0] ref_bf16(input logic [15:0] v);
    logic [7:0] e; logic [15:0] m, e5, s, r;
    e = v[14:7]; m = {9'b0, v[6:0]};
    e5 = (e < 8'h71) ? 0 : {8'b0, e} - 16'h70;
    if (e < 8'h6E) m = 0;
    else if (e == 8'h6E) m = (m != 0) ? 16'h20 : 0;
    else if (e == 8'h6F) m = (m >= 16'h40) ? 16'h40 : 16'h20;
    else if (e == 8'h70) m = (m > 16'h20) ? ((m >= 16'h60) ? 16'h80 : 16'h60) : 16'h40;
    s = (e5 << 7) | m;
    r = s + 16'h000F + ((s >> 5) & 1);
    if (e > 8'h8E || s >= 16'h0F70) r = 16'h0F7F;
    if (e == 8'hFF && v[6:0] != 0) r = 16'h0FC0;
    r = r | (v & 16'h8000) >> 3;
    return r[12:5];
  endfunction

  function automatic logic [31:0] ref_word(input logic [127:0] d, input bit md);
    logic [31:0] o;
    for (int l = 0; l < 4; l++)
      o[l*8 +: 8] = md ? ref_bf16(d[l*32+16 +: 16]) : ref_f32(d[l*32 +: 32]);
    return o;
  endfunction

  function automatic void check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endfunction

  task automatic send(input logic [127:0] d, input bit md, input string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_mode = md;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    it.exp = ref_word(d, md); it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: drives out_ready on the falling edge, judges the transfer just after
  initial begin : mon
    logic [31:0] held;
    bit was_stalled;
    was_stalled = 0; held = '0;
    forever begin
      @(negedge clk);
      out_ready = rnd_ready ? ($urandom_range(0, 2) != 0) : 1'b1;
      #1;
      if (rst_n && was_stalled && out_valid)
        check(out_data == held, "R11 hold while stalled", out_data, held);
      was_stalled = out_valid && !out_ready;
      held = out_data;
      if (rst_n && out_valid && out_ready) begin
        if (sb.size() == 0) check(1'b0, "R10 unexpected beat", out_data, 32'h0);
        else begin
          item_t it;
          it = sb.pop_front();
          check(out_data == it.exp, it.tag, out_data, it.exp);
        end
      end
    end
  end

  initial begin : wdog
    #(200000 * 5);
    if (!run_done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : drv
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R10 out_valid after reset", {31'b0, out_valid}, 32'h0);
    check(in_ready == 1'b1, "R10 in_ready after reset", {31'b0, in_ready}, 32'h1);
    @(negedge clk); rst_n = 1'b1;

    send({32'h3F800000, 32'h00000000, 32'h80000000, 32'hBF800000}, 0, "R1 R7 unit and zeros");
    send({32'h36FFFFFF, 32'h00000001, 32'h37000000, 32'hB6800000}, 0, "R2 below snap range");
    send({32'h37000001, 32'h377FFFFF, 32'h37C00000, 32'h38200000}, 0, "R3 snap 6E 6F 70");
    send({32'h38200001, 32'h38600000, 32'h385FFFFF, 32'hB8000000}, 0, "R3 snap at 70");
    send({32'h3F900000, 32'h3FB00000, 32'h3F900001, 32'h3FAFFFFF}, 0, "R4 ties to even");
    send({32'h47600000, 32'h476FFFFF, 32'h47700000, 32'h47800000}, 0, "R5 overflow edge");
    send({32'h7F800000, 32'hFF800000, 32'h7FC00000, 32'hFF800001}, 0, "R5 R6 inf and NaN");
    send({32'h3F900001, 32'h7F800001, 32'h3F80FFFF, 32'h3780FFFF}, 1, "R8 bf16 low half ignored");
    send({32'h7F800001, 32'h7FC00000, 32'h3790FFFF, 32'hC7700000}, 1, "R8 bf16 specials");
    send({32'h7F800001, 32'h37000001, 32'hFF800000, 32'h3FB00000}, 0, "R9 mixed lanes");

    rnd_ready = 1;
    for (int n = 0; n < 400; n++) begin
      logic [127:0] d;
      for (int l = 0; l < 4; l++) begin
        logic [31:0] w;
        w = $urandom;
        if ($urandom_range(0, 1) == 1) w[30:23] = 8'(8'h6C + $urandom_range(0, 36));
        d[l*32 +: 32] = w;
      end
      send(d, 1'($urandom_range(0, 1)), "R9 random beat");
    end
    rnd_ready = 0;

    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R10 drained", {31'b0, out_valid}, 32'h0);
    run_done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule